// File: doc/BRIEF.md
# Prioritized Transmit Mailbox Scheduler

This block keeps a small set of outgoing message slots for a CAN-style controller and decides which one goes to the protocol engine next. Software loads a slot's identifier, length code and payload while the slot is free. It then sets a request that makes the slot eligible for sending. The scheduler orders eligible slots in one of two ways. By default the numerically smallest identifier wins. With the ordering switch set, slots are served in the order they were requested.

When the bus reports idle and nothing is being sent, the scheduler launches the winning slot with a one-cycle start pulse and a registered copy of its contents. It then waits for the engine's done pulse, which carries success, lost-arbitration and error bits. A failed attempt is retried unless single-shot mode is on or an abort is waiting. Each slot keeps its own completion, success, arbitration-lost and error flags. A free-slot code tells software where to load the next message.

Top module: `tx_mailbox_sched`

## Requirements
- R1: A write lands in the addressed slot only while that slot is empty. A write to a slot that is pending, scheduled or transmitting leaves the stored message unchanged.
- R2: A request to an empty slot makes it non-empty on the next cycle. `free_valid`/`free_code` give the lowest-numbered empty slot, and `free_valid` is 0 when no slot is empty.
- R3: With `cfg_fifo_order`=0, the pending slot with the smallest identifier is launched first. Equal identifiers go to the lower slot number.
- R4: With `cfg_fifo_order`=1, pending slots are launched in the order their requests were accepted, whatever their identifiers.
- R5: A launch happens only on a cycle with `bus_idle`=1 and no slot transmitting. It shows as a single-cycle `eng_start` one cycle later, with `eng_sel`, `eng_id`, `eng_dlc` and `eng_data` from the launched slot. At most one slot is ever transmitting.
- R6: A done pulse with `eng_ok`=1 empties the transmitting slot and sets its `done_flag` and `ok_flag`.
- R7: With `cfg_single_shot`=0, a failed attempt returns the slot to pending and it is launched again. `arb_flag` and `err_flag` latch `eng_arb_lost` and `eng_err`, and `done_flag` stays 0.
- R8: With `cfg_single_shot`=1, a failed attempt empties the slot. It sets `done_flag`, leaves `ok_flag` 0 and latches the failure bits. No retry follows.
- R9: An abort to a pending or scheduled slot empties it on the next cycle with `done_flag`=1 and `ok_flag`=0, and it is never launched.
- R10: An abort to a transmitting slot waits for the outcome. On success the slot empties with `ok_flag`=1. On failure it empties with `ok_flag`=0 and `done_flag`=1, and it is not retried.
- R11: An accepted request clears that slot's four status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_order | input | 1 | 1: request order, 0: identifier priority |
| cfg_single_shot | input | 1 | 1: one attempt per request |
| wr_en | input | 1 | Load message into slot `wr_sel` |
| wr_sel | input | 2 | Slot addressed by a write |
| wr_id | input | 29 | Identifier to load |
| wr_dlc | input | 4 | Length code to load |
| wr_data | input | 64 | Payload to load |
| req_en | input | 1 | Request transmission of slot `req_sel` |
| req_sel | input | 2 | Slot addressed by a request |
| abort_en | input | 1 | Abort slot `abort_sel` |
| abort_sel | input | 2 | Slot addressed by an abort |
| bus_idle | input | 1 | Bus is free for a new frame |
| eng_done | input | 1 | Engine finished the current attempt |
| eng_ok | input | 1 | Attempt succeeded (with `eng_done`) |
| eng_arb_lost | input | 1 | Arbitration lost (with `eng_done`) |
| eng_err | input | 1 | Transmit error (with `eng_done`) |
| eng_start | output | 1 | One-cycle launch pulse |
| eng_sel | output | 2 | Launched slot number |
| eng_id | output | 29 | Launched identifier |
| eng_dlc | output | 4 | Launched length code |
| eng_data | output | 64 | Launched payload |
| mb_empty | output | 3 | Per-slot empty indication |
| free_valid | output | 1 | At least one slot is empty |
| free_code | output | 2 | Lowest empty slot number |
| done_flag | output | 3 | Per-slot request complete |
| ok_flag | output | 3 | Per-slot success |
| arb_flag | output | 3 | Per-slot arbitration lost |
| err_flag | output | 3 | Per-slot transmit error |

## Verification
The assertions assume that the engine raises `eng_done` only while a slot is transmitting. They also assume that each done pulse lasts one cycle and that the three slot-select inputs stay within the slot count. The bench models the engine. It answers each `eng_start` with exactly one single-cycle done pulse and never sends one otherwise. All selects it drives are 0 to 2.

In request-order mode, the assertions also assume that few enough requests occur while one slot waits that its two-bit tag cannot wrap. The bench never re-requests a slot while an older one is still pending.

// File: rtl/txmb_pkg.sv
package txmb_pkg;
  typedef enum logic [1:0] {
    MB_EMPTY = 2'd0,
    MB_PEND  = 2'd1,
    MB_SCHED = 2'd2,
    MB_XMIT  = 2'd3
  } mb_state_e;
endpackage

// File: rtl/txmb_slot.sv
module txmb_slot
  import txmb_pkg::*;
#(
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  parameter int SEQ_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hit,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DLC_W-1:0]  wr_dlc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_hit,
  input  logic              abort_hit,
  input  logic [SEQ_W-1:0]  seq_in,
  input  logic              xmit_busy,
  input  logic              pick_me,
  input  logic              launch,
  input  logic              single_shot,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic              eng_arb_lost,
  input  logic              eng_err,
  output mb_state_e         state_o,
  output logic [ID_W-1:0]   id_o,
  output logic [DLC_W-1:0]  dlc_o,
  output logic [DATA_W-1:0] data_o,
  output logic [SEQ_W-1:0]  seq_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              arb_o,
  output logic              err_o
);

  logic abort_wait;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o    <= MB_EMPTY;
      id_o       <= '0;
      dlc_o      <= '0;
      data_o     <= '0;
      seq_o      <= '0;
      done_o     <= 1'b0;
      ok_o       <= 1'b0;
      arb_o      <= 1'b0;
      err_o      <= 1'b0;
      abort_wait <= 1'b0;
    end else begin
      if (wr_hit && state_o == MB_EMPTY) begin
        id_o   <= wr_id;
        dlc_o  <= wr_dlc;
        data_o <= wr_data;
      end
      case (state_o)
        MB_EMPTY: begin
          if (req_hit) begin
            state_o    <= MB_PEND;
            seq_o      <= seq_in;
            done_o     <= 1'b0;
            ok_o       <= 1'b0;
            arb_o      <= 1'b0;
            err_o      <= 1'b0;
            abort_wait <= 1'b0;
          end
        end
        MB_PEND, MB_SCHED: begin
          if (abort_hit) begin
            state_o <= MB_EMPTY;
            done_o  <= 1'b1;
            ok_o    <= 1'b0;
          end else if (launch) begin
            state_o <= MB_XMIT;
          end else if (!xmit_busy) begin
            state_o <= pick_me ? MB_SCHED : MB_PEND;
          end
        end
        default: begin
          if (abort_hit) abort_wait <= 1'b1;
          if (eng_done) begin
            if (eng_ok) begin
              state_o <= MB_EMPTY;
              done_o  <= 1'b1;
              ok_o    <= 1'b1;
            end else begin
              arb_o <= arb_o | eng_arb_lost;
              err_o <= err_o | eng_err;
              if (single_shot || abort_wait || abort_hit) begin
                state_o <= MB_EMPTY;
                done_o  <= 1'b1;
                ok_o    <= 1'b0;
              end else begin
                state_o <= MB_PEND;
              end
            end
          end
        end
      endcase
    end
  end

  assert_write_locked_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && state_o != MB_EMPTY) |=> $stable(id_o) && $stable(data_o));

  assert_request_taken_R2: assert property (@(posedge clk) disable iff (rst)
    (req_hit && state_o == MB_EMPTY) |=> state_o == MB_PEND);

  assert_success_empties_R6: assert property (@(posedge clk) disable iff (rst)
    (eng_done && eng_ok && state_o == MB_XMIT) |=> (state_o == MB_EMPTY && ok_o && done_o));

  assert_single_shot_R8: assert property (@(posedge clk) disable iff (rst)
    (eng_done && single_shot && state_o == MB_XMIT) |=> (state_o == MB_EMPTY && done_o));

  assert_abort_waiting_R9: assert property (@(posedge clk) disable iff (rst)
    (abort_hit && (state_o == MB_PEND || state_o == MB_SCHED))
      |=> (state_o == MB_EMPTY && done_o && !ok_o));

endmodule

// File: rtl/txmb_pick.sv
module txmb_pick #(
  parameter int N     = 3,
  parameter int ID_W  = 29,
  parameter int SEQ_W = 2,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      cand,
  input  logic [N*ID_W-1:0] ids,
  input  logic [N*SEQ_W-1:0] seqs,
  input  logic [SEQ_W-1:0]  seq_now,
  input  logic              fifo_mode,
  output logic              valid,
  output logic [SEL_W-1:0]  sel
);

  logic [SEQ_W-1:0] age [N];
  logic [ID_W-1:0]  idv [N];
  logic [ID_W-1:0]  best_id;
  logic [SEQ_W-1:0] best_age;

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign idv[g] = ids[g*ID_W +: ID_W];
    assign age[g] = seq_now - seqs[g*SEQ_W +: SEQ_W];
  end

  always_comb begin
    valid    = 1'b0;
    sel      = '0;
    best_id  = '0;
    best_age = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!valid || (fifo_mode ? (age[i] > best_age) : (idv[i] < best_id)))) begin
        valid    = 1'b1;
        sel      = SEL_W'(i);
        best_id  = idv[i];
        best_age = age[i];
      end
    end
  end

endmodule

// File: rtl/tx_mailbox_sched.sv
module tx_mailbox_sched
  import txmb_pkg::*;
#(
  parameter int N      = 3,
  parameter int ID_W   = 29,
  parameter int DLC_W  = 4,
  parameter int DATA_W = 64,
  parameter int SEQ_W  = 2,
  localparam int SEL_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_fifo_order,
  input  logic              cfg_single_shot,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ID_W-1:0]   wr_id,
  input  logic [DLC_W-1:0]  wr_dlc,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              req_en,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              abort_en,
  input  logic [SEL_W-1:0]  abort_sel,
  input  logic              bus_idle,
  input  logic              eng_done,
  input  logic              eng_ok,
  input  logic              eng_arb_lost,
  input  logic              eng_err,
  output logic              eng_start,
  output logic [SEL_W-1:0]  eng_sel,
  output logic [ID_W-1:0]   eng_id,
  output logic [DLC_W-1:0]  eng_dlc,
  output logic [DATA_W-1:0] eng_data,
  output logic [N-1:0]      mb_empty,
  output logic              free_valid,
  output logic [SEL_W-1:0]  free_code,
  output logic [N-1:0]      done_flag,
  output logic [N-1:0]      ok_flag,
  output logic [N-1:0]      arb_flag,
  output logic [N-1:0]      err_flag
);

  mb_state_e         st     [N];
  logic [ID_W-1:0]   id_a   [N];
  logic [DLC_W-1:0]  dlc_a  [N];
  logic [DATA_W-1:0] data_a [N];
  logic [SEQ_W-1:0]  seq_a  [N];

  logic [N-1:0]       cand, xmit_vec, req_hit, launch_vec;
  logic [N*ID_W-1:0]  ids_flat;
  logic [N*SEQ_W-1:0] seqs_flat;
  logic [SEQ_W-1:0]   seq_cnt;
  logic               pick_valid, xmit_busy, launch_ok;
  logic [SEL_W-1:0]   pick_sel;

  assign xmit_busy = |xmit_vec;
  assign launch_ok = pick_valid && bus_idle && !xmit_busy
                     && !(abort_en && abort_sel == pick_sel);

  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
    assign cand[g]       = (st[g] == MB_PEND) || (st[g] == MB_SCHED);
    assign xmit_vec[g]   = (st[g] == MB_XMIT);
    assign mb_empty[g]   = (st[g] == MB_EMPTY);
    assign req_hit[g]    = req_en && (req_sel == IDX) && mb_empty[g];
    assign launch_vec[g] = launch_ok && (pick_sel == IDX);
    assign ids_flat[g*ID_W +: ID_W]    = id_a[g];
    assign seqs_flat[g*SEQ_W +: SEQ_W] = seq_a[g];

    txmb_slot #(.ID_W(ID_W), .DLC_W(DLC_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_slot (
      .clk(clk), .rst(rst),
      .wr_hit(wr_en && wr_sel == IDX), .wr_id(wr_id), .wr_dlc(wr_dlc), .wr_data(wr_data),
      .req_hit(req_hit[g]), .abort_hit(abort_en && abort_sel == IDX),
      .seq_in(seq_cnt), .xmit_busy(xmit_busy),
      .pick_me(pick_valid && pick_sel == IDX), .launch(launch_vec[g]),
      .single_shot(cfg_single_shot),
      .eng_done(eng_done), .eng_ok(eng_ok), .eng_arb_lost(eng_arb_lost), .eng_err(eng_err),
      .state_o(st[g]), .id_o(id_a[g]), .dlc_o(dlc_a[g]), .data_o(data_a[g]), .seq_o(seq_a[g]),
      .done_o(done_flag[g]), .ok_o(ok_flag[g]), .arb_o(arb_flag[g]), .err_o(err_flag[g])
    );
  end

  txmb_pick #(.N(N), .ID_W(ID_W), .SEQ_W(SEQ_W)) u_pick (
    .cand(cand), .ids(ids_flat), .seqs(seqs_flat), .seq_now(seq_cnt),
    .fifo_mode(cfg_fifo_order), .valid(pick_valid), .sel(pick_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_cnt   <= '0;
      eng_start <= 1'b0;
      eng_sel   <= '0;
      eng_id    <= '0;
      eng_dlc   <= '0;
      eng_data  <= '0;
    end else begin
      if (|req_hit) seq_cnt <= seq_cnt + 1'b1;
      eng_start <= launch_ok;
      if (launch_ok) begin
        eng_sel  <= pick_sel;
        eng_id   <= id_a[pick_sel];
        eng_dlc  <= dlc_a[pick_sel];
        eng_data <= data_a[pick_sel];
      end
    end
  end

  always_comb begin
    free_valid = 1'b0;
    free_code  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mb_empty[i]) begin
        free_valid = 1'b1;
        free_code  = SEL_W'(i);
      end
    end
  end

  assert_single_xmit_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(xmit_vec));

  assert_start_on_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_start) |-> $past(bus_idle));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    eng_start |=> !eng_start);

endmodule

// File: tb/tx_mailbox_sched_bench.sv
module tx_mailbox_sched_bench;
  localparam int N = 3;
  localparam int ID_W = 29;
  localparam int DLC_W = 4;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fifo_order = 1'b0, cfg_single_shot = 1'b0;
  logic wr_en = 1'b0, req_en = 1'b0, abort_en = 1'b0;
  logic [1:0] wr_sel = '0, req_sel = '0, abort_sel = '0;
  logic [ID_W-1:0] wr_id = '0;
  logic [DLC_W-1:0] wr_dlc = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic bus_idle = 1'b0;
  logic eng_done = 1'b0, eng_ok = 1'b0, eng_arb_lost = 1'b0, eng_err = 1'b0;
  logic eng_start;
  logic [1:0] eng_sel;
  logic [ID_W-1:0] eng_id;
  logic [DLC_W-1:0] eng_dlc;
  logic [DATA_W-1:0] eng_data;
  logic [N-1:0] mb_empty, done_flag, ok_flag, arb_flag, err_flag;
  logic free_valid;
  logic [1:0] free_code;

  int n_chk = 0;
  int n_fail = 0;
  bit got;
  int ids [N];
  bit used [N];

  always #10 clk = ~clk;

  tx_mailbox_sched u_tx_mailbox_sched (
    .clk(clk), .rst(rst), .cfg_fifo_order(cfg_fifo_order), .cfg_single_shot(cfg_single_shot),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_id(wr_id), .wr_dlc(wr_dlc), .wr_data(wr_data),
    .req_en(req_en), .req_sel(req_sel), .abort_en(abort_en), .abort_sel(abort_sel),
    .bus_idle(bus_idle), .eng_done(eng_done), .eng_ok(eng_ok),
    .eng_arb_lost(eng_arb_lost), .eng_err(eng_err),
    .eng_start(eng_start), .eng_sel(eng_sel), .eng_id(eng_id), .eng_dlc(eng_dlc),
    .eng_data(eng_data), .mb_empty(mb_empty), .free_valid(free_valid), .free_code(free_code),
    .done_flag(done_flag), .ok_flag(ok_flag), .arb_flag(arb_flag), .err_flag(err_flag)
  );

  task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic do_write(input int s, input int id, input int dlc);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(s); wr_id = ID_W'(id); wr_dlc = 4'(dlc);
    wr_data = {2{3'b0, ID_W'(id)}};
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_req(input int s);
    @(negedge clk);
    req_en = 1'b1; req_sel = 2'(s);
    @(negedge clk);
    req_en = 1'b0;
  endtask

  task automatic do_abort(input int s);
    @(negedge clk);
    abort_en = 1'b1; abort_sel = 2'(s);
    @(negedge clk);
    abort_en = 1'b0;
  endtask

  task automatic wait_start(output bit found);
    found = 1'b0;
    for (int k = 0; k < 12 && !found; k++) begin
      @(negedge clk);
      if (eng_start) found = 1'b1;
    end
  endtask

  task automatic finish_tx(input bit ok, input bit al, input bit er);
    eng_done = 1'b1; eng_ok = ok; eng_arb_lost = al; eng_err = er;
    @(negedge clk);
    eng_done = 1'b0; eng_ok = 1'b0; eng_arb_lost = 1'b0; eng_err = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(mb_empty == 3'b111 && free_valid && free_code == 0 && !eng_start,
        "R2 reset state", {mb_empty, free_valid, free_code}, 64'h3c);
    chk(done_flag == 0 && ok_flag == 0 && arb_flag == 0 && err_flag == 0,
        "R6 reset flags", {done_flag, ok_flag, arb_flag, err_flag}, 0);

    // R1: write after request is ignored; R5: no start while bus busy
    do_write(0, 100, 8);
    do_req(0);
    chk(!mb_empty[0] && free_code == 1, "R2 free code after request", free_code, 1);
    do_write(0, 7, 2);
    got = 1'b0;
    repeat (4) begin @(negedge clk); if (eng_start) got = 1'b1; end
    chk(!got, "R5 no launch while bus busy", got, 0);
    bus_idle = 1'b1;
    wait_start(got);
    chk(got && eng_sel == 0 && eng_id == 100 && eng_dlc == 8, "R1 locked slot keeps message",
        eng_id, 100);
    chk(eng_data == {2{3'b0, ID_W'(100)}}, "R5 payload copy", eng_data, {2{3'b0, ID_W'(100)}});
    @(negedge clk);
    chk(!eng_start, "R5 start is one cycle", eng_start, 0);
    finish_tx(1'b1, 1'b0, 1'b0);
    chk(mb_empty[0] && done_flag[0] && ok_flag[0], "R6 success empties",
        {mb_empty[0], done_flag[0], ok_flag[0]}, 7);

    // R3: identifier priority sweep
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++) begin
          bus_idle = 1'b0;
          ids[0] = 40 + a; ids[1] = 40 + b; ids[2] = 40 + c;
          for (int s = 0; s < N; s++) begin do_write(s, ids[s], s + 1); used[s] = 1'b0; end
          for (int s = 0; s < N; s++) do_req(s);
          chk(!free_valid, "R2 no free slot when all requested", free_valid, 0);
          bus_idle = 1'b1;
          for (int k = 0; k < N; k++) begin
            int best;
            best = -1;
            for (int s = 0; s < N; s++)
              if (!used[s] && (best < 0 || ids[s] < ids[best])) best = s;
            used[best] = 1'b1;
            wait_start(got);
            chk(got && eng_sel == 2'(best) && eng_id == ID_W'(ids[best]),
                "R3 identifier order", {eng_sel, 8'(eng_id)}, {2'(best), 8'(ids[best])});
            finish_tx(1'b1, 1'b0, 1'b0);
            chk(done_flag[best] && ok_flag[best], "R6 flags after success",
                {done_flag[best], ok_flag[best]}, 3);
          end
        end

    // R4: request-order sweep over all permutations
    cfg_fifo_order = 1'b1;
    for (int p = 0; p < 6; p++) begin
      int ord [N];
      ord[0] = p / 2;
      ord[1] = (p % 2 == 0) ? ((ord[0] + 1) % 3) : ((ord[0] + 2) % 3);
      ord[2] = 3 - ord[0] - ord[1];
      bus_idle = 1'b0;
      for (int s = 0; s < N; s++) do_write(s, 30 - 10 * s, 1);
      for (int k = 0; k < N; k++) do_req(ord[k]);
      bus_idle = 1'b1;
      for (int k = 0; k < N; k++) begin
        wait_start(got);
        chk(got && eng_sel == 2'(ord[k]), "R4 request order", eng_sel, ord[k]);
        finish_tx(1'b1, 1'b0, 1'b0);
      end
    end
    cfg_fifo_order = 1'b0;

    // R7: automatic retry
    do_write(1, 55, 3);
    do_req(1);
    wait_start(got);
    chk(got && eng_sel == 1, "R7 first attempt", eng_sel, 1);
    finish_tx(1'b0, 1'b0, 1'b1);
    chk(!mb_empty[1] && err_flag[1] && !done_flag[1] && !arb_flag[1], "R7 failure kept pending",
        {mb_empty[1], err_flag[1], done_flag[1]}, 3'b010);
    wait_start(got);
    chk(got && eng_sel == 1, "R7 retried", eng_sel, 1);
    finish_tx(1'b1, 1'b0, 1'b0);
    chk(mb_empty[1] && ok_flag[1] && done_flag[1], "R7 retry succeeds", ok_flag[1], 1);

    // R11: new request clears flags
    do_req(1);
    chk(!done_flag[1] && !ok_flag[1] && !err_flag[1], "R11 flags cleared by request",
        {done_flag[1], ok_flag[1], err_flag[1]}, 0);
    wait_start(got);
    // R8: single shot
    cfg_single_shot = 1'b1;
    finish_tx(1'b0, 1'b1, 1'b0);
    chk(mb_empty[1] && done_flag[1] && !ok_flag[1] && arb_flag[1], "R8 single attempt",
        {mb_empty[1], done_flag[1], ok_flag[1], arb_flag[1]}, 4'b1101);
    got = 1'b0;
    repeat (5) begin @(negedge clk); if (eng_start) got = 1'b1; end
    chk(!got, "R8 no retry", got, 0);
    cfg_single_shot = 1'b0;

    // R9: abort while pending
    bus_idle = 1'b0;
    do_write(2, 9, 1);
    do_req(2);
    do_abort(2);
    chk(mb_empty[2] && done_flag[2] && !ok_flag[2], "R9 abort pending",
        {mb_empty[2], done_flag[2], ok_flag[2]}, 3'b110);
    bus_idle = 1'b1;
    got = 1'b0;
    repeat (5) begin @(negedge clk); if (eng_start) got = 1'b1; end
    chk(!got, "R9 aborted slot never launched", got, 0);

    // R10: abort during transmit, then success
    do_req(2);
    wait_start(got);
    do_abort(2);
    chk(!mb_empty[2], "R10 abort waits for outcome", mb_empty[2], 0);
    finish_tx(1'b1, 1'b0, 1'b0);
    chk(mb_empty[2] && ok_flag[2] && done_flag[2], "R10 abort then success",
        {ok_flag[2], done_flag[2]}, 3);

    // R10: abort during transmit, then failure
    do_req(2);
    wait_start(got);
    do_abort(2);
    finish_tx(1'b0, 1'b1, 1'b0);
    chk(mb_empty[2] && !ok_flag[2] && done_flag[2], "R10 abort then failure",
        {mb_empty[2], ok_flag[2], done_flag[2]}, 3'b101);
    got = 1'b0;
    repeat (5) begin @(negedge clk); if (eng_start) got = 1'b1; end
    chk(!got, "R10 no retry after abort", got, 0);

    summary();
  end
endmodule